// File: doc/BRIEF.md
# ADC Control and Result Register Interface

This block is the digital shell around a 10-bit successive-approximation converter core. Software sees three byte-wide registers on a small single-cycle bus: a control/status register, an upper result byte and a lower result byte. Setting the enable bit first lets a programmable settling counter run out. After that the block starts the core and keeps it converting the selected channel back-to-back, with no further software trigger.

Each finished conversion sets a completion flag and loads both result registers in the same clock. The 10-bit value is split into its eight upper bits and its two lower bits. Software polls the flag, because the block raises no interrupt. Reading the upper byte clears the flag and reading the lower byte leaves it alone. A halt input switches the converter off exactly as clearing enable does. A wait input changes nothing.

The core sits behind a one-cycle start pulse, a channel number, a power-on level and a one-cycle done pulse that carries the result.

Top module: `adc_ctrl_regif`

## Requirements
- R1: After reset, all three registers read 0x00, `conv_power` is low and `conv_start` is low.
- R2: Writing the control register (address 0) with bit 5 set and bits [2:0] = channel turns the converter on. Bit 5 is enable and bits [2:0] select the channel. The write lands at clock edge E0, `conv_power` rises at E0+1, and the first `conv_start` pulse is high in the cycle after edge E0+`settle_len`+2. `conv_chan` equals the channel field.
- R3: Each `conv_start` pulse lasts one cycle. After an accepted completion, while the converter stays enabled and not halted, `conv_start` pulses again in the very next cycle.
- R4: An accepted completion sets the flag (control bit 7) and loads the upper register (address 1) and the lower register (address 2) in the same clock.
- R5: The upper register holds result bits [9:2]. The lower register holds result bits [1:0] in bits [1:0] and zeros in bits [7:2]. So 0x3FF reads 0xFF/0x03 and 0x000 reads 0x00/0x00.
- R6: A read of the upper register clears the flag. A completion in the same cycle wins and leaves the flag set.
- R7: A read of the lower register or of the control register leaves the flag unchanged.
- R8: Clearing enable drops `conv_power` one cycle after the write. It stops all start pulses. Any done pulse that arrives while powered down is ignored, and the flag and the results keep their values.
- R9: While `halt_req` is high the converter is off, as in R8. When halt is released with enable still set, settling starts again and the first start pulse comes `settle_len`+2 cycles after the cycle in which halt dropped.
- R10: `wait_req` has no effect: power stays on and conversions continue.
- R11: Done pulses that arrive during settling, before the first start pulse, are never marked complete.
- R12: Writes to the result registers are ignored. The flag bit of the control register cannot be written.
- R13: The pair is not locked. A completion between a lower-byte read and an upper-byte read makes the upper read return the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control/status, 1 upper result, 2 lower result |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| settle_len | input | STAB_W | Settling cycles before the first conversion |
| wait_req | input | 1 | Wait-mode indication (no effect) |
| halt_req | input | 1 | Halt-mode indication (converter off) |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_chan | output | 3 | Channel to convert |
| conv_power | output | 1 | Core powered and in use |
| conv_done | input | 1 | One-cycle completion from the core |
| conv_result | input | 10 | Result valid with `conv_done` |

## Verification
A sequencer stuck in or skipping a state shows at `conv_start` within a few cycles. It appears as a start that comes early or late against the settling count, as a missing restart after a completion, or as a start while powered down. A flag that is wrong, or a done pulse taken while off, is visible at the next control-register read. A swapped or shifted result split shows on the first upper or lower read after a completion, and the full-scale and zero inputs make bit-slice errors plain. An ordering fault in the flag logic shows at once on a low-then-high read pair.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int RES_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int CH_W    = 3;
  localparam int ADDR_W  = 2;
  localparam int LO_BITS = RES_W - BYTE_W;
  localparam int EN_POS  = 5;
  localparam int FLAG_POS = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd2;

  typedef enum logic [1:0] {
    SQ_OFF    = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_START  = 2'd2,
    SQ_BUSY   = 2'd3
  } sq_state_e;

  function automatic logic [BYTE_W-1:0] upper_byte(input logic [RES_W-1:0] r);
    return r[RES_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lower_byte(input logic [RES_W-1:0] r);
    return {{(BYTE_W-LO_BITS){1'b0}}, r[LO_BITS-1:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_image(input logic flag, input logic en,
                                                   input logic [CH_W-1:0] ch);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[FLAG_POS] = flag;
    v[EN_POS]   = en;
    v[CH_W-1:0] = ch;
    return v;
  endfunction
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_regif_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              halt,
  input  logic [STAB_W-1:0] settle_len,
  input  logic              core_done,
  output logic              conv_start,
  output logic              conv_power,
  output logic              done_evt,
  output logic              settle_done,
  output logic              active
);
  sq_state_e         state_q, state_d;
  logic [STAB_W-1:0] cnt_q, cnt_d;

  assign active      = en & ~halt;
  assign settle_done = (state_q == SQ_SETTLE) && (cnt_q >= settle_len);
  assign done_evt    = (state_q == SQ_BUSY) && core_done && active;
  assign conv_start  = (state_q == SQ_START);
  assign conv_power  = (state_q != SQ_OFF);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!active) begin
      state_d = SQ_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SQ_OFF: begin
          state_d = SQ_SETTLE;
          cnt_d   = '0;
        end
        SQ_SETTLE: begin
          if (settle_done) state_d = SQ_START;
          else             cnt_d   = cnt_q + 1'b1;
        end
        SQ_START: state_d = SQ_BUSY;
        SQ_BUSY:  if (done_evt) state_d = SQ_START;
        default:  state_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank
  import adc_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              done_evt,
  input  logic [RES_W-1:0]  core_result,
  output logic              en_q,
  output logic [CH_W-1:0]   chan_q,
  output logic              eoc_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              rd_hi,
  output logic              rd_lo
);
  logic wr_ctrl;

  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  assign rd_hi   = bus_sel & ~bus_wr & (bus_addr == A_HI);
  assign rd_lo   = bus_sel & ~bus_wr & (bus_addr == A_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      chan_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= bus_wdata[EN_POS];
      chan_q <= bus_wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eoc_q <= 1'b0;
    else if (done_evt) eoc_q <= 1'b1;
    else if (rd_hi)    eoc_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (done_evt) begin
      hi_q <= upper_byte(core_result);
      lo_q <= lower_byte(core_result);
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_image(eoc_q, en_q, chan_q);
      A_HI:    bus_rdata = hi_q;
      A_LO:    bus_rdata = lo_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_ctrl_regif.sv
module adc_ctrl_regif
  import adc_regif_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [STAB_W-1:0] settle_len,
  input  logic              wait_req,
  input  logic              halt_req,
  output logic              conv_start,
  output logic [2:0]        conv_chan,
  output logic              conv_power,
  input  logic              conv_done,
  input  logic [9:0]        conv_result
);
  logic              en_q, eoc_q, rd_hi, rd_lo;
  logic              done_evt, settle_done, active;
  logic [CH_W-1:0]   chan_q;
  logic [BYTE_W-1:0] hi_q, lo_q;

  adc_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_evt(done_evt), .core_result(conv_result),
    .en_q(en_q), .chan_q(chan_q), .eoc_q(eoc_q),
    .hi_q(hi_q), .lo_q(lo_q), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  adc_seq_fsm #(.STAB_W(STAB_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .en(en_q), .halt(halt_req), .settle_len(settle_len),
    .core_done(conv_done),
    .conv_start(conv_start), .conv_power(conv_power),
    .done_evt(done_evt), .settle_done(settle_done), .active(active)
  );

  assign conv_chan = chan_q;
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wait_req,
  input logic       halt_req,
  input logic       conv_start,
  input logic       conv_power,
  input logic [9:0] conv_result,
  input logic       done_evt,
  input logic       active,
  input logic       eoc_q,
  input logic       rd_hi,
  input logic       rd_lo,
  input logic [7:0] hi_q,
  input logic [7:0] lo_q
);
  // R6
  eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && !done_evt |=> !eoc_q);
  // R6
  eoc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> eoc_q);
  // R4
  load_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (hi_q == $past(conv_result[9:2])) && (lo_q[1:0] == $past(conv_result[1:0])));
  // R7
  lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && eoc_q |=> eoc_q);
  // R5
  lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q[7:2] == 6'd0);
  // R8
  off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_power |-> !conv_start);
  // R8
  off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_power |-> !done_evt);
  // R9
  halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !conv_power);
  // R11
  settle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_power) |-> !conv_start);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && active |=> conv_start);
  // R10
  wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_power && active && wait_req |=> conv_power);
endmodule

bind adc_ctrl_regif adc_regif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .halt_req(halt_req),
  .conv_start(conv_start), .conv_power(conv_power), .conv_result(conv_result),
  .done_evt(done_evt), .active(active), .eoc_q(eoc_q),
  .rd_hi(rd_hi), .rd_lo(rd_lo), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/adc_ctrl_regif_tb_top.sv
module adc_ctrl_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] settle_len = '0;
  logic       wait_req = 1'b0, halt_req = 1'b0;
  logic       conv_start, conv_power;
  logic [2:0] conv_chan;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;

  int unsigned cyc = 0;
  int checks = 0, errors = 0;
  logic [9:0] analog [8];
  int lat = 3;
  int inj_req = 0, inj_seen = 0;
  logic [9:0] inj_val = '0;
  logic       rbusy = 1'b0;
  int         rcnt = 0;
  logic [2:0] rch = '0;

  adc_ctrl_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .settle_len(settle_len), .wait_req(wait_req), .halt_req(halt_req),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_power(conv_power),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural core: answers each start after lat+1 cycles
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (inj_req != inj_seen) begin
      inj_seen    <= inj_req;
      conv_done   <= 1'b1;
      conv_result <= inj_val;
    end else if (rbusy) begin
      if (rcnt == 0) begin
        conv_done   <= 1'b1;
        conv_result <= analog[rch];
        rbusy       <= 1'b0;
      end else rcnt <= rcnt - 1;
    end
    if (conv_start) begin
      rbusy <= 1'b1;
      rcnt  <= lat;
      rch   <= conv_chan;
    end
  end

  function automatic logic [7:0] exp_hi(input logic [9:0] v);
    return 8'(v / 4);
  endfunction
  function automatic logic [7:0] exp_lo(input logic [9:0] v);
    return 8'(v % 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic poll_flag(input string req);
    logic [7:0] d;
    d = '0;
    for (int i = 0; i < 300; i++) begin
      bus_read(2'd0, d);
      if (d[7]) break;
    end
    check(req, {31'd0, d[7]}, 32'd1);
  endtask

  // returns the number of negedges from now until conv_start is first seen
  task automatic time_first_start(output int n);
    n = -1;
    for (int i = 0; i < 400; i++) begin
      if (conv_start) begin n = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [9:0] v;
    logic [7:0] last_hi;
    int n, bad, starts;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 8; c++) analog[c] = 10'(c * 97 + 5);

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 power", {31'd0, conv_power}, 0);
    check("R1 start", {31'd0, conv_start}, 0);
    bus_read(2'd0, d); check("R1 ctrl", d, 8'h00);
    rst_n = 1'b1;
    bus_read(2'd0, d); check("R1 ctrl", d, 8'h00);
    bus_read(2'd1, d); check("R1 hi", d, 8'h00);
    bus_read(2'd2, d); check("R1 lo", d, 8'h00);

    // R12 result registers and flag bit are not writable
    bus_write(2'd1, 8'hA5); bus_write(2'd2, 8'hFF); bus_write(2'd0, 8'h80);
    bus_read(2'd1, d); check("R12 hi write", d, 8'h00);
    bus_read(2'd2, d); check("R12 lo write", d, 8'h00);
    bus_read(2'd0, d); check("R12 flag write", d, 8'h00);

    // R2 + R11: settle timing, early done ignored
    settle_len = 8'd10;
    bus_write(2'd0, 8'h20 | 8'd6);
    check("R2 chan", {29'd0, conv_chan}, 6);
    @(negedge clk);
    check("R2 power", {31'd0, conv_power}, 1);
    inj_val = 10'h3AA; inj_req++;
    repeat (2) @(negedge clk);
    bus_read(2'd0, d); check("R11 early done", d, 8'h26);
    bus_write(2'd0, 8'h00);
    settle_len = 8'd5;
    bus_write(2'd0, 8'h20 | 8'd3);
    time_first_start(n);
    check("R2 first start", n, 5 + 2);
    bus_read(2'd1, d); check("R11 hi untouched", d, 8'h00);

    // R3 restart right after a completion
    while (conv_done !== 1'b1) @(posedge clk);
    @(negedge clk);
    check("R3 restart", {31'd0, conv_start}, 1);
    @(negedge clk);
    check("R3 one cycle", {31'd0, conv_start}, 0);

    // R7 then R6 on a held result
    poll_flag("R4 flag");
    bus_write(2'd0, 8'h03);
    bus_read(2'd2, d); check("R5 lo", d, exp_lo(analog[3]));
    bus_read(2'd0, d); check("R7 lo keeps flag", d, 8'h83);
    bus_read(2'd1, d); check("R5 hi", d, exp_hi(analog[3]));
    bus_read(2'd0, d); check("R6 hi clears flag", d, 8'h03);
    last_hi = d;
    last_hi = exp_hi(analog[3]);

    // R4 R5 random and corner values
    for (int it = 0; it < 24; it++) begin
      logic [2:0] ch;
      ch = 3'($urandom % 8);
      if (it == 0)      v = 10'h3FF;
      else if (it == 1) v = 10'h000;
      else              v = 10'($urandom % 1024);
      analog[ch] = v;
      settle_len = 8'($urandom % 4);
      lat = int'($urandom % 5);
      bus_write(2'd0, 8'h20 | 8'(ch));
      poll_flag("R4 flag set");
      bus_read(2'd2, d); check("R5 lo random", d, exp_lo(v));
      bus_read(2'd1, d); check("R5 hi random", d, exp_hi(v));
      last_hi = exp_hi(v);
      bus_write(2'd0, 8'h00);
      bus_read(2'd1, d);
    end

    // R8 disable while a conversion is in flight
    lat = 6; settle_len = 0;
    analog[1] = {~last_hi, 2'b01};
    bus_write(2'd0, 8'h21);
    time_first_start(n);
    bus_write(2'd0, 8'h01);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (conv_power || conv_start) bad++;
    end
    check("R8 stays off", bad, 0);
    bus_read(2'd0, d); check("R8 flag", d, 8'h01);
    bus_read(2'd1, d); check("R8 hi kept", d, last_hi);

    // R10 wait mode changes nothing
    lat = 2;
    bus_write(2'd0, 8'h21);
    wait_req = 1'b1;
    bad = 0; starts = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 3 && !conv_power) bad++;
      if (conv_start) starts++;
    end
    wait_req = 1'b0;
    check("R10 power", bad, 0);
    check("R10 converting", {31'd0, starts > 3}, 1);

    // R9 halt and resettle
    bus_read(2'd1, d);
    analog[1] = {~d, 2'b10};
    lat = 6;
    while (conv_start !== 1'b1) @(negedge clk);
    halt_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (conv_power || conv_start) bad++;
    end
    check("R9 halted", bad, 0);
    bus_read(2'd1, d); check("R9 hi kept", d, 8'(~analog[1][9:2]));
    settle_len = 8'd4;
    @(negedge clk);
    halt_req = 1'b0;
    time_first_start(n);
    check("R9 resettle", n, 4 + 2);

    // R13 result overwritten between low and high reads
    lat = 3;
    poll_flag("R13 flag");
    bus_read(2'd2, d);
    analog[1] = 10'h2C6;
    while (conv_done !== 1'b1) @(posedge clk);
    @(negedge clk);
    bus_read(2'd1, d); check("R13 new hi", d, exp_hi(10'h2C6));
    bus_write(2'd0, 8'h00);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule